// File: doc/BRIEF.md
# Paced-Peripheral DMA Handshake Sequencer

This block produces the pin-level handshake timing for one DMA channel that moves data to or from a paced peripheral. Software loads a beat count and three timing fields, then pulses `start_i` while the channel is enabled. The channel then waits for the peripheral's request. Each request produces one beat with three phases: an address setup delay, an acknowledge strobe stretched by a programmable wait, and a hold tail. The beat count is in units of the peripheral width, not bytes, and it counts down by one per beat.

The request, acknowledge and end-of-transfer pins each have their own active-low select. The end-of-transfer pin works in one of two directions. As an output, it marks the last beat of a terminal-count run. As an input, it lets the peripheral stop the transfer early. Two sticky flags record which of these two events ended the run. The terminal-count stop select decides whether reaching zero halts the channel or lets it keep running with a wrapped count.

Top module: `dma_hs_seq`

## Requirements
- R1: While `en_i` is low, `start_i` has no effect: `busy_o` stays low and `remain_o` and the flags keep their values. With `en_i` high and the channel idle, `start_i` loads `count_i` into `remain_o` and clears both flags. If the count is non-zero, it also raises `busy_o` on the next cycle.
- R2: A busy channel starts a beat only in a cycle where the request is active. The request is active when `req_pin_i` differs from `req_low_i`. Until then, acknowledge stays inactive and `busy_o` stays high.
- R3: With the request held active, acknowledge becomes active 1+S cycles after the channel is armed or after the previous beat's last acknowledge cycle. S is the setup field (0..3), and S=0 adds no cycle.
- R4: Acknowledge stays active for exactly 1+W+H consecutive cycles per beat. W is the wait field (0..63) and H is the hold field (0..7).
- R5: A pin is at its active level when it differs from its active-low select. Acknowledge is at its inactive level whenever the channel is idle.
- R6: `remain_o` drops by one at the end of each beat, and the number of beats equals the loaded count.
- R7: When the last beat ends, `cnt_stat_o` is set. It stays set until the next accepted start. With `tc_stop_i` high, `busy_o` then falls and `done_o` pulses for one cycle.
- R8: With `tc_stop_i` low, reaching zero sets `cnt_stat_o` but the channel stays busy. The next beat wraps `remain_o` to all ones.
- R9: With `eot_out_i` high, `eot_oe_o` is high and the end-of-transfer pin is active only during the last acknowledge cycle of the terminal-count beat.
- R10: With `eot_out_i` low, an active level on `eot_pin_i` while busy sets `xfer_stat_o` and leaves `cnt_stat_o` clear. A beat in progress completes, and the channel then stops. Between beats, the channel stops on the next cycle.
- R11: Dropping `en_i` between beats stops the channel on the next cycle. Dropping it during a beat lets that beat finish at full length first.
- R12: A start with a count of zero sets `cnt_stat_o` at once and does not raise `busy_o`.
- R13: The setup, wait and hold fields are captured at start. Changing them during a run does not alter that run's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| start_i | input | 1 | Start pulse, accepted when enabled and idle |
| count_i | input | CNT_W | Beat count in peripheral-width units |
| setup_cyc_i | input | PSC_W | Setup phase length in cycles |
| wait_cyc_i | input | PWC_W | Wait cycles added to the acknowledge strobe |
| hold_cyc_i | input | PHC_W | Hold phase length in cycles |
| tc_stop_i | input | 1 | Stop the channel when the count reaches zero |
| eot_out_i | input | 1 | 1: end-of-transfer pin is a terminal-count output; 0: input |
| req_low_i | input | 1 | Request pin is active low |
| ack_low_i | input | 1 | Acknowledge pin is active low |
| eot_low_i | input | 1 | End-of-transfer pin is active low |
| req_pin_i | input | 1 | Peripheral request pin |
| eot_pin_i | input | 1 | End-of-transfer pin, input side |
| ack_pin_o | output | 1 | Peripheral acknowledge pin |
| eot_pin_o | output | 1 | End-of-transfer pin, output side |
| eot_oe_o | output | 1 | Output enable for the end-of-transfer pin |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the channel returns to idle |
| cnt_stat_o | output | 1 | Sticky: count reached zero |
| xfer_stat_o | output | 1 | Sticky: external end-of-transfer seen |
| remain_o | output | CNT_W | Beats remaining |

## Verification
The bench builds the block with its default widths: a 16-bit count, a 2-bit setup field, a 6-bit wait field and a 3-bit hold field. This makes the longest beat of 3+1+63+7 cycles reachable, and lets a single beat from zero show the 16-bit wrap. Random runs vary the three timing fields, all three polarities and the end-of-transfer direction. They also scramble the timing inputs after each start. Directed runs cover all-zero phases, a request held off, early end of transfer during a beat and between beats, loss of enable, a zero count and continuation past terminal count.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_SETUP,
    PH_XFER,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/dma_hs_pol.sv
module dma_hs_pol #(
  parameter int N = 2
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] low_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign lvl_o[g] = lvl_i[g] ^ low_i[g];
  end
endmodule

// File: rtl/dma_hs_count.sv
module dma_hs_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             last_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     remain_q <= '0;
    else if (load_i) remain_q <= load_val_i;
    else if (dec_i)  remain_q <= remain_q - CNT_W'(1);
  end

  assign remain_o = remain_q;
  assign last_o   = (remain_q == CNT_W'(1));
endmodule

// File: rtl/dma_hs_phase.sv
module dma_hs_phase
  import dma_hs_pkg::*;
#(
  parameter int PSC_W = 2,
  parameter int PWC_W = 6,
  parameter int PHC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             req_act_i,
  input  logic             stop_i,
  input  logic [PSC_W-1:0] setup_i,
  input  logic [PWC_W-1:0] wait_i,
  input  logic [PHC_W-1:0] hold_i,
  output logic             busy_o,
  output logic             ack_act_o,
  output logic             beat_end_o,
  output logic             done_o
);
  localparam int CW_A = (PWC_W > PHC_W) ? PWC_W : PHC_W;
  localparam int CW   = (CW_A > PSC_W) ? CW_A : PSC_W;

  phase_e           state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [PSC_W-1:0] setup_q;
  logic [PWC_W-1:0] wait_q;
  logic [PHC_W-1:0] hold_q;
  logic             done_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    beat_end_o = 1'b0;
    unique case (state_q)
      PH_IDLE: if (arm_i) state_d = PH_ARM;
      PH_ARM: begin
        if (stop_i) begin
          state_d = PH_IDLE;
        end else if (req_act_i) begin
          if (setup_q != '0) begin
            state_d = PH_SETUP;
            cnt_d   = CW'(setup_q) - CW'(1);
          end else begin
            state_d = PH_XFER;
            cnt_d   = CW'(wait_q);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          state_d = PH_XFER;
          cnt_d   = CW'(wait_q);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_XFER: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CW'(1);
        end else if (hold_q != '0) begin
          state_d = PH_HOLD;
          cnt_d   = CW'(hold_q) - CW'(1);
        end else begin
          beat_end_o = 1'b1;
          state_d    = stop_i ? PH_IDLE : PH_ARM;
        end
      end
      PH_HOLD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CW'(1);
        end else begin
          beat_end_o = 1'b1;
          state_d    = stop_i ? PH_IDLE : PH_ARM;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_q != PH_IDLE) && (state_d == PH_IDLE);
    end
  end

  // timing fields frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
    end else if (arm_i && state_q == PH_IDLE) begin
      setup_q <= setup_i;
      wait_q  <= wait_i;
      hold_q  <= hold_i;
    end
  end

  assign busy_o    = (state_q != PH_IDLE);
  assign ack_act_o = (state_q == PH_XFER) || (state_q == PH_HOLD);
  assign done_o    = done_q;
endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2,
  parameter int PWC_W = 6,
  parameter int PHC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PSC_W-1:0] setup_cyc_i,
  input  logic [PWC_W-1:0] wait_cyc_i,
  input  logic [PHC_W-1:0] hold_cyc_i,
  input  logic             tc_stop_i,
  input  logic             eot_out_i,
  input  logic             req_low_i,
  input  logic             ack_low_i,
  input  logic             eot_low_i,
  input  logic             req_pin_i,
  input  logic             eot_pin_i,
  output logic             ack_pin_o,
  output logic             eot_pin_o,
  output logic             eot_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cnt_stat_o,
  output logic             xfer_stat_o,
  output logic [CNT_W-1:0] remain_o
);
  logic [1:0] pin_in, act_in, act_out, pin_out;
  logic       req_act, eot_in_act;
  logic       busy, ack_act, beat_end, last;
  logic       start_ok, arm, eot_req, tc_hit, stop, eot_tc;
  logic       cnt_stat_q, xfer_stat_q;

  assign pin_in = {req_pin_i, eot_pin_i};
  dma_hs_pol #(.N(2)) i_pol_in (
    .lvl_i(pin_in),
    .low_i({req_low_i, eot_low_i}),
    .lvl_o(act_in)
  );
  assign req_act    = act_in[1];
  assign eot_in_act = act_in[0];

  assign start_ok = start_i && en_i && !busy;
  assign arm      = start_ok && (count_i != '0);
  assign eot_req  = busy && !eot_out_i && eot_in_act;
  assign tc_hit   = beat_end && last;
  assign stop     = !en_i || eot_req || xfer_stat_q || (tc_hit && tc_stop_i);
  assign eot_tc   = tc_hit && eot_out_i;

  dma_hs_phase #(
    .PSC_W(PSC_W),
    .PWC_W(PWC_W),
    .PHC_W(PHC_W)
  ) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .req_act_i (req_act),
    .stop_i    (stop),
    .setup_i   (setup_cyc_i),
    .wait_i    (wait_cyc_i),
    .hold_i    (hold_cyc_i),
    .busy_o    (busy),
    .ack_act_o (ack_act),
    .beat_end_o(beat_end),
    .done_o    (done_o)
  );

  dma_hs_count #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_ok),
    .load_val_i(count_i),
    .dec_i     (beat_end),
    .remain_o  (remain_o),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_stat_q  <= 1'b0;
      xfer_stat_q <= 1'b0;
    end else if (start_ok) begin
      cnt_stat_q  <= (count_i == '0);
      xfer_stat_q <= 1'b0;
    end else begin
      if (tc_hit)  cnt_stat_q  <= 1'b1;
      if (eot_req) xfer_stat_q <= 1'b1;
    end
  end

  assign act_out = {ack_act, eot_tc};
  dma_hs_pol #(.N(2)) i_pol_out (
    .lvl_i(act_out),
    .low_i({ack_low_i, eot_low_i}),
    .lvl_o(pin_out)
  );
  assign ack_pin_o   = pin_out[1];
  assign eot_pin_o   = pin_out[0];
  assign eot_oe_o    = eot_out_i;
  assign busy_o      = busy;
  assign cnt_stat_o  = cnt_stat_q;
  assign xfer_stat_o = xfer_stat_q;
endmodule

// File: rtl/dma_hs_seq_chk.sv
module dma_hs_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             start_i,
  input logic             eot_out_i,
  input logic             ack_low_i,
  input logic             eot_low_i,
  input logic             ack_pin_o,
  input logic             eot_pin_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             cnt_stat_o,
  input logic [CNT_W-1:0] remain_o
);
  // R5
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ack_pin_o == ack_low_i));

  // R9
  eot_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_pin_o != eot_low_i) |-> (eot_out_i && (ack_pin_o != ack_low_i)));

  // R7
  cnt_stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_stat_o && !start_i) |=> cnt_stat_o);

  // R7
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R6
  remain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((remain_o == $past(remain_o)) ||
                  (remain_o == $past(remain_o) - CNT_W'(1))));

  // R1
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && start_i && !busy_o) |=> !busy_o);
endmodule

bind dma_hs_seq dma_hs_seq_chk #(.CNT_W(CNT_W)) i_dma_hs_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .start_i   (start_i),
  .eot_out_i (eot_out_i),
  .ack_low_i (ack_low_i),
  .eot_low_i (eot_low_i),
  .ack_pin_o (ack_pin_o),
  .eot_pin_o (eot_pin_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cnt_stat_o(cnt_stat_o),
  .remain_o  (remain_o)
);

// File: tb/test_dma_hs_seq.sv
module test_dma_hs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, start = 1'b0;
  logic [15:0] count = '0;
  logic [1:0]  setup = '0;
  logic [5:0]  waitc = '0;
  logic [2:0]  hold = '0;
  logic        tc_stop = 1'b1, eot_out = 1'b0;
  logic        req_low = 1'b0, ack_low = 1'b0, eot_low = 1'b0;
  logic        req_pin = 1'b0, eot_pin = 1'b0;
  logic        ack_pin, eot_pin_o, eot_oe, busy, done, cnt_stat, xfer_stat;
  logic [15:0] remain;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_hs_seq i_dma_hs_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .count_i(count),
    .setup_cyc_i(setup), .wait_cyc_i(waitc), .hold_cyc_i(hold),
    .tc_stop_i(tc_stop), .eot_out_i(eot_out),
    .req_low_i(req_low), .ack_low_i(ack_low), .eot_low_i(eot_low),
    .req_pin_i(req_pin), .eot_pin_i(eot_pin),
    .ack_pin_o(ack_pin), .eot_pin_o(eot_pin_o), .eot_oe_o(eot_oe),
    .busy_o(busy), .done_o(done), .cnt_stat_o(cnt_stat),
    .xfer_stat_o(xfer_stat), .remain_o(remain)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // mode: 0 none, 1 eot in beat, 2 eot between beats, 3 enable drop in beat
  task automatic run_xfer(input int cnt, input int s, input int w, input int h,
                          input logic rl, input logic al, input logic el,
                          input logic eo, input int mode, input string tag);
    int beats = 0, width = 0, gap = 0, eot_cnt = 0, eot_bad = 0;
    int gap_bad = 0, wid_bad = 0, guard = 0, exp_beats, exp_eot;
    logic prev = 1'b0, ack, eact, done_seen;
    req_low = rl; ack_low = al; eot_low = el; eot_out = eo;
    tc_stop = 1'b1; en = 1'b1; req_pin = ~rl; eot_pin = el;
    count = cnt[15:0]; setup = s[1:0]; waitc = w[5:0]; hold = h[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R13: scramble timing inputs after start
    setup = 2'($urandom); waitc = 6'($urandom); hold = 3'($urandom);
    while (busy && guard < 20000) begin
      ack  = ack_pin ^ al;
      eact = eot_pin_o ^ el;
      if (ack) begin
        if (!prev) begin
          beats++;
          if (gap != 1 + s) gap_bad++;
          gap = 0;
          if (mode == 1) eot_pin = ~el;
          if (mode == 3) en = 1'b0;
        end
        width++;
      end else begin
        if (prev) begin
          if (width != 1 + w + h) wid_bad++;
          width = 0;
          if (mode == 2) eot_pin = ~el;
        end
        gap++;
      end
      if (eact) begin
        eot_cnt++;
        if (!ack) eot_bad++;
      end
      prev = ack;
      guard++;
      @(negedge clk);
    end
    done_seen = done;
    if (prev && width != 1 + w + h) wid_bad++;
    eot_pin = el;
    en = 1'b1;
    exp_beats = (mode == 0) ? cnt : 1;
    exp_eot   = (mode == 0 && eo) ? 1 : 0;
    chk(beats == exp_beats, {tag, " R6 beat count"}, beats, exp_beats);
    chk(gap_bad == 0, {tag, " R3 setup gap"}, gap_bad, 0);
    chk(wid_bad == 0, {tag, " R4/R13 ack width"}, wid_bad, 0);
    chk(int'(remain) == cnt - exp_beats, {tag, " R6 remain"}, int'(remain), cnt - exp_beats);
    chk(cnt_stat == (mode == 0), {tag, " R7 cnt_stat"}, int'(cnt_stat), int'(mode == 0));
    chk(xfer_stat == (mode == 1 || mode == 2), {tag, " R10 xfer_stat"},
        int'(xfer_stat), int'(mode == 1 || mode == 2));
    chk(done_seen == 1'b1, {tag, " R7 done pulse"}, int'(done_seen), 1);
    chk(eot_cnt == exp_eot && eot_bad == 0, {tag, " R9 eot output"}, eot_cnt, exp_eot);
    chk(eot_oe == eo, {tag, " R9 eot_oe"}, int'(eot_oe), int'(eo));
    chk(ack_pin == al, {tag, " R5 ack idle level"}, int'(ack_pin), int'(al));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired R1 actual=0 expected=1");
    finish_run();
  end

  initial begin
    int prev_rem;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    // reset state (R1, R5)
    chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'(busy), 0);
    chk(ack_pin == 1'b0, "R5 reset ack level", int'(ack_pin), 0);
    chk(cnt_stat == 1'b0 && xfer_stat == 1'b0, "R7 reset flags", int'(cnt_stat), 0);
    chk(remain == 16'd0, "R6 reset remain", int'(remain), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: zero count
    en = 1'b1; count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R12 zero count busy", int'(busy), 0);
    chk(cnt_stat == 1'b1, "R12 zero count cnt_stat", int'(cnt_stat), 1);

    // R1: start ignored while disabled
    prev_rem = int'(remain);
    en = 1'b0; count = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 disabled start busy", int'(busy), 0);
    chk(int'(remain) == prev_rem, "R1 disabled start remain", int'(remain), prev_rem);
    chk(cnt_stat == 1'b1, "R1 disabled start flag kept", int'(cnt_stat), 1);
    en = 1'b1;

    // directed corner cases
    run_xfer(2, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 0, "zero_phases");
    run_xfer(2, 3, 63, 7, 1'b1, 1'b1, 1'b1, 1'b1, 0, "max_phases");
    run_xfer(5, 1, 3, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R10 eot_in_beat");
    run_xfer(5, 2, 1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R10 eot_between");
    run_xfer(3, 0, 5, 1, 1'b0, 1'b0, 1'b0, 1'b1, 3, "R11 en_drop_beat");

    // R2: request held off (active low request)
    req_low = 1'b1; ack_low = 1'b0; eot_out = 1'b0; eot_low = 1'b0; eot_pin = 1'b0;
    tc_stop = 1'b1; req_pin = 1'b1;
    count = 16'd1; setup = '0; waitc = '0; hold = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(ack_pin == 1'b0 && busy == 1'b1, "R2 no request no ack", int'(ack_pin), 0);
    req_pin = 1'b0;
    @(negedge clk);
    chk(ack_pin == 1'b1, "R2 request starts beat", int'(ack_pin), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R2 single beat done", int'(busy), 0);

    // R8: continue past terminal count, then R11 enable drop between beats
    req_low = 1'b0; req_pin = 1'b1; tc_stop = 1'b0;
    count = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b1 && cnt_stat == 1'b1, "R8 tc no stop", int'(busy), 1);
    chk(remain == 16'd0, "R8 remain at tc", int'(remain), 0);
    repeat (2) @(negedge clk);
    chk(remain == 16'hFFFF, "R8 wrap", int'(remain), 65535);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R11 en drop between beats", int'(busy), 0);
    en = 1'b1; tc_stop = 1'b1;

    // constrained random runs
    for (int i = 0; i < 12; i++) begin
      int c, s, w, h;
      logic rl, al, el, eo;
      c  = 1 + int'($urandom_range(3));
      s  = int'($urandom_range(3));
      w  = (i % 4 == 3) ? 63 : int'($urandom_range(20));
      h  = int'($urandom_range(7));
      rl = 1'($urandom); al = 1'($urandom); el = 1'($urandom); eo = 1'($urandom);
      run_xfer(c, s, w, h, rl, al, el, eo, 0, "random");
    end

    finish_run();
  end
endmodule